// File: doc/BRIEF.md
# Load-Linked Word Load Datapath

This block carries out the load half of a load-linked word operation. A request supplies a base register value, a 9-bit signed displacement and a destination register index. The block adds the sign-extended displacement to the base to form the effective address and checks that the address is word aligned. A misaligned address produces an address-error pulse and no memory traffic. An aligned address becomes a doubleword memory read. Endian configuration bits decide which half of the returned doubleword is taken. The chosen 32-bit word is sign-extended to 64 bits and written back to the destination register. In the same cycle, a strobe tells the reservation logic to set its link flag.

Requests use a valid/ready handshake. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The two configuration inputs are sampled on that same edge. `req_ready` is high only while the unit is idle, so a caller must hold its request until it is accepted. The outgoing memory read is also valid/ready: `mem_req_valid` and `mem_req_addr` stay constant until the memory raises `mem_req_ready`. At most one read is outstanding. The memory returns its data with a one-cycle `mem_rsp_valid` pulse, which the unit always accepts. Writeback, link and error outputs are one-cycle strobes with no back-pressure.

Top module: `llw_load_unit`

## Requirements
- R1: The effective address equals `req_base` plus `req_offset` sign-extended from 9 to 64 bits, with 64-bit wrap-around.
- R2: When bits 1:0 of the effective address are not both zero, `addr_err` pulses for one cycle, one cycle after acceptance, and `err_vaddr` carries the effective address. In that case no memory read is issued and neither `wb_valid` nor `link_set` pulses.
- R3: For an aligned request, `mem_req_addr` keeps effective-address bits 63:3. Its bits 2:0 are effective-address bits 2:0 XORed with {`cfg_reverse_endian`, 2'b00}.
- R4: The byte index is effective-address bits 2:0 XORed with {`cfg_big_endian`, 2'b00}. Index 0 selects `mem_rsp_data[31:0]` and index 4 selects `mem_rsp_data[63:32]`.
- R5: `wb_data[31:0]` is the selected word, and every bit of `wb_data[63:32]` equals bit 31 of that word.
- R6: `wb_valid` pulses for one cycle, in the cycle after the accepted `mem_rsp_valid`, with `wb_rd` equal to the request's `req_rd`. `link_set` pulses in exactly the same cycle.
- R7: `req_ready` is low from the acceptance of an aligned request until its writeback, and stays high after a misaligned one. The configuration inputs are used as they stood at acceptance.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` stays unchanged on the next cycle.
- R9: Out of reset, `req_ready` is high and `mem_req_valid`, `wb_valid`, `link_set` and `addr_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_big_endian | input | 1 | Processor byte order; flips word selection |
| cfg_reverse_endian | input | 1 | Reversed user byte order; flips address bit 2 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_base | input | 64 | Base register value |
| req_offset | input | 9 | Signed displacement |
| req_rd | input | 5 | Destination register index |
| mem_req_valid | output | 1 | Doubleword read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Physical read address |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 64 | Returned doubleword |
| wb_valid | output | 1 | Register writeback strobe |
| wb_rd | output | 5 | Writeback register index |
| wb_data | output | 64 | Sign-extended loaded word |
| link_set | output | 1 | Strobe that sets the link reservation |
| addr_err | output | 1 | Address-error exception strobe |
| err_vaddr | output | 64 | Faulting effective address |

## Verification
The bench builds the unit with its default parameters: a 64-bit register, a 32-bit word and a 9-bit displacement. With these values both displacement extremes (-256 and +255) can be reached, as can carries out of bit 31 and wrap-around through zero. Both word lanes are exercised under all four combinations of the two endian bits. A memory model with random stalls and a latency of one to three cycles holds the read handshake open. The configuration inputs are inverted right after every acceptance, which shows that the values present at acceptance are the ones used.

// File: rtl/llw_pkg.sv
package llw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } llw_state_e;
endpackage

// File: rtl/llw_addr_gen.sv
module llw_addr_gen #(
  parameter int XLEN    = 64,
  parameter int OFF_W   = 9,
  parameter int ALIGN_W = 2,
  parameter int BIDX_W  = 3
) (
  input  logic [XLEN-1:0]  base,
  input  logic [OFF_W-1:0] offset,
  input  logic             rev_endian,
  output logic [XLEN-1:0]  ea,
  output logic             misaligned,
  output logic [XLEN-1:0]  paddr
);
  localparam int LANE_W = BIDX_W - ALIGN_W;

  logic [XLEN-1:0]   off_ext;
  logic [BIDX_W-1:0] low_flip;

  always_comb begin
    off_ext    = {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
    ea         = base + off_ext;
    misaligned = |ea[ALIGN_W-1:0];
    low_flip   = {{LANE_W{rev_endian}}, {ALIGN_W{1'b0}}};
    paddr      = {ea[XLEN-1:BIDX_W], ea[BIDX_W-1:0] ^ low_flip};
  end
endmodule

// File: rtl/llw_word_steer.sv
module llw_word_steer #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  logic [XLEN-1:0]                    dword,
  input  logic [$clog2(XLEN/WORD_W)-1:0]     lane_sel,
  output logic [XLEN-1:0]                    value
);
  localparam int NLANE = XLEN / WORD_W;

  logic [WORD_W-1:0] lanes [NLANE];
  logic [WORD_W-1:0] word;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lanes[g] = dword[g*WORD_W +: WORD_W];
  end

  always_comb begin
    word  = lanes[lane_sel];
    value = {{(XLEN-WORD_W){word[WORD_W-1]}}, word};
  end
endmodule

// File: rtl/llw_ctrl.sv
module llw_ctrl
  import llw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic misaligned,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  output logic req_ready,
  output logic cap_en,
  output logic err_en,
  output logic mem_req_valid,
  output logic rsp_en
);
  llw_state_e state_q, state_d;
  logic       fire;

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    fire          = req_valid && req_ready;
    cap_en        = fire && !misaligned;
    err_en        = fire && misaligned;
    mem_req_valid = (state_q == ST_ISSUE);
    rsp_en        = (state_q == ST_WAIT) && mem_rsp_valid;
    state_d       = state_q;
    unique case (state_q)
      ST_IDLE:  if (cap_en) state_d = ST_ISSUE;
      ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R8: a read request waits in place until the memory takes it
  a_r8_issue_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ISSUE && !mem_req_ready) |=> (state_q == ST_ISSUE));

  // R7: the unit leaves idle only through an aligned acceptance
  a_r7_busy_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !cap_en) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/llw_load_unit.sv
module llw_load_unit #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32,
  parameter int OFF_W  = 9,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_big_endian,
  input  logic              cfg_reverse_endian,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [XLEN-1:0]   req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [RIDX_W-1:0] req_rd,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_rd,
  output logic [XLEN-1:0]   wb_data,
  output logic              link_set,
  output logic              addr_err,
  output logic [XLEN-1:0]   err_vaddr
);
  localparam int ALIGN_W = $clog2(WORD_W/8);
  localparam int BIDX_W  = $clog2(XLEN/8);
  localparam int LANE_W  = BIDX_W - ALIGN_W;

  logic [XLEN-1:0]   ea, paddr, steered;
  logic              misaligned, cap_en, err_en, rsp_en;
  logic [LANE_W-1:0] lane_now;

  logic [XLEN-1:0]   pend_addr_q;
  logic [LANE_W-1:0] pend_lane_q;
  logic [RIDX_W-1:0] pend_rd_q;
  logic              wb_valid_q, link_q, err_q;
  logic [RIDX_W-1:0] wb_rd_q;
  logic [XLEN-1:0]   wb_data_q, err_vaddr_q;

  llw_addr_gen #(
    .XLEN(XLEN), .OFF_W(OFF_W), .ALIGN_W(ALIGN_W), .BIDX_W(BIDX_W)
  ) i_addr (
    .base(req_base), .offset(req_offset), .rev_endian(cfg_reverse_endian),
    .ea(ea), .misaligned(misaligned), .paddr(paddr)
  );

  llw_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .misaligned(misaligned),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .req_ready(req_ready), .cap_en(cap_en), .err_en(err_en),
    .mem_req_valid(mem_req_valid), .rsp_en(rsp_en)
  );

  llw_word_steer #(.XLEN(XLEN), .WORD_W(WORD_W)) i_steer (
    .dword(mem_rsp_data), .lane_sel(pend_lane_q), .value(steered)
  );

  assign lane_now = ea[BIDX_W-1:ALIGN_W] ^ {LANE_W{cfg_big_endian}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr_q <= '0;
      pend_lane_q <= '0;
      pend_rd_q   <= '0;
    end else if (cap_en) begin
      pend_addr_q <= paddr;
      pend_lane_q <= lane_now;
      pend_rd_q   <= req_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid_q  <= 1'b0;
      link_q      <= 1'b0;
      wb_rd_q     <= '0;
      wb_data_q   <= '0;
      err_q       <= 1'b0;
      err_vaddr_q <= '0;
    end else begin
      wb_valid_q <= rsp_en;
      link_q     <= rsp_en;
      err_q      <= err_en;
      if (rsp_en) begin
        wb_rd_q   <= pend_rd_q;
        wb_data_q <= steered;
      end
      if (err_en) err_vaddr_q <= ea;
    end
  end

  assign mem_req_addr = pend_addr_q;
  assign wb_valid     = wb_valid_q;
  assign wb_rd        = wb_rd_q;
  assign wb_data      = wb_data_q;
  assign link_set     = link_q;
  assign addr_err     = err_q;
  assign err_vaddr    = err_vaddr_q;

  // R2: an exception never coincides with a writeback or link strobe
  a_r2_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> !wb_valid && !link_set);

  // R2: a faulting request leaves the unit idle with no read outstanding
  a_r2_err_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> !mem_req_valid && req_ready);

  // R5: upper half of every written value copies the word sign bit
  a_r5_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_data[XLEN-1:WORD_W] == {(XLEN-WORD_W){wb_data[WORD_W-1]}}));

  // R6: writeback is a single-cycle strobe following a response
  a_r6_wb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);
  a_r6_wb_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(mem_rsp_valid));
  a_r6_link_with_wb: assert property (@(posedge clk) disable iff (!rst_n)
    link_set == wb_valid);

  // R7: no new request accepted while a read is pending
  a_r7_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R8: pending read address held under back-pressure
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));
endmodule

// File: tb/test_llw_load_unit.sv
`timescale 1ns/1ps
module test_llw_load_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big_endian = 1'b0, cfg_reverse_endian = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [63:0] req_base = '0;
  logic [8:0]  req_offset = '0;
  logic [4:0]  req_rd = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        wb_valid, link_set, addr_err;
  logic [4:0]  wb_rd;
  logic [63:0] wb_data, err_vaddr;

  always #5 clk = ~clk;

  llw_load_unit i_llw_load_unit (.*);

  typedef struct { bit err; logic [4:0] rd; logic [63:0] val; } exp_t;
  exp_t        exp_q[$];
  logic [63:0] paddr_q[$];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    return {a[31:0] ^ 32'hC3A5_96F0, a[31:0] ^ 32'h3C5A_690F};
  endfunction

  // Driver: computes expectations from the requirements, then handshakes
  task automatic issue(input logic [63:0] base, input logic [8:0] off,
                       input logic [4:0] rd, input bit big, input bit rev);
    logic [63:0] ea, dw;
    logic [31:0] w;
    exp_t e;
    bit mis;
    ea  = base + {{55{off[8]}}, off};                       // R1
    mis = (ea[1:0] != 2'b00);
    if (mis) begin
      e.err = 1; e.rd = rd; e.val = ea;                     // R2
    end else begin
      paddr_q.push_back({ea[63:3], ea[2:0] ^ {rev, 2'b00}}); // R3
      dw = mem_word({ea[63:3], 3'b000});
      w  = ((ea[2] ^ big) == 1'b1) ? dw[63:32] : dw[31:0];   // R4
      e.err = 0; e.rd = rd; e.val = {{32{w[31]}}, w};       // R5
    end
    exp_q.push_back(e);
    req_base = base; req_offset = off; req_rd = rd;
    cfg_big_endian = big; cfg_reverse_endian = rev;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_big_endian = ~big; cfg_reverse_endian = ~rev;       // R7 sampling
    chk(req_ready == mis, "R7", "req_ready after acceptance",
        {63'd0, req_ready}, {63'd0, mis});
  endtask

  // Monitor: pops the scoreboard as results appear
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && (wb_valid || link_set || addr_err)) begin
        chk(link_set == wb_valid, "R6", "link_set with wb_valid",
            {63'd0, link_set}, {63'd0, wb_valid});
        chk(!(addr_err && wb_valid), "R2", "error and writeback together",
            {63'd0, wb_valid}, 64'd0);
        if (addr_err || wb_valid) begin
          if (exp_q.size() == 0) begin
            chk(0, "R2", "unexpected result", {63'd0, wb_valid}, 64'd0);
          end else begin
            e = exp_q.pop_front();
            if (addr_err) begin
              chk(e.err, "R2", "address error raised", 64'd1, {63'd0, e.err});
              chk(err_vaddr == e.val, "R1", "faulting address", err_vaddr, e.val);
            end else begin
              chk(!e.err, "R2", "writeback on misaligned", 64'd1, {63'd0, e.err});
              chk(wb_rd == e.rd, "R6", "wb_rd", {59'd0, wb_rd}, {59'd0, e.rd});
              chk(wb_data == e.val, "R4 R5", "wb_data", wb_data, e.val);
            end
          end
        end
      end
    end
  end

  // Memory model with random back-pressure and latency
  initial begin
    logic [63:0] held, last_addr, ex;
    int cnt = 0;
    bit was_stall = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_rsp_valid = 0; mem_req_ready = 0; cnt = 0; was_stall = 0;
        continue;
      end
      if (was_stall)
        chk(mem_req_valid && mem_req_addr == last_addr, "R8", "held read address",
            mem_req_addr, last_addr);
      mem_rsp_valid = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data  = mem_word({held[63:3], 3'b000});
        end
      end
      mem_req_ready = ($urandom % 3) != 0;
      was_stall = 0;
      if (mem_req_valid) begin
        if (mem_req_ready) begin
          if (paddr_q.size() == 0) begin
            chk(0, "R2", "read without aligned request", mem_req_addr, 64'd0);
          end else begin
            ex = paddr_q.pop_front();
            chk(mem_req_addr == ex, "R3", "read address", mem_req_addr, ex);
          end
          held = mem_req_addr;
          cnt  = 1 + int'($urandom % 3);
        end else begin
          was_stall = 1;
          last_addr = mem_req_addr;
        end
      end
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !wb_valid && !link_set && !addr_err,
        "R9", "reset state",
        {59'd0, req_ready, mem_req_valid, wb_valid, link_set, addr_err}, 64'h10);

    // Lanes under each endian combination (R3, R4)
    issue(64'h0000_0000_0000_1000, 9'd0, 5'd1, 0, 0);
    issue(64'h0000_0000_0000_1000, 9'd4, 5'd2, 0, 0);
    issue(64'h0000_0000_0000_1000, 9'd0, 5'd3, 1, 0);
    issue(64'h0000_0000_0000_1000, 9'd4, 5'd4, 1, 1);
    issue(64'h0000_0000_8000_2000, 9'd0, 5'd5, 0, 1);
    issue(64'h0000_0000_8000_2000, 9'd4, 5'd6, 1, 1);
    // Displacement extremes and carries (R1)
    issue(64'h0000_0000_0000_0400, 9'h100, 5'd7, 0, 0);
    issue(64'h0000_0000_0000_0400, 9'h0FC, 5'd8, 1, 0);
    issue(64'h0000_0000_FFFF_FFF8, 9'd8, 5'd9, 0, 0);
    issue(64'h0000_0000_0000_0000, 9'h1FC, 5'd10, 0, 1);
    issue(64'h0000_0000_0000_1001, 9'd3, 5'd11, 1, 0);
    // Misaligned traps, back to back (R2)
    issue(64'h0000_0000_0000_1000, 9'd1, 5'd12, 0, 0);
    issue(64'h0000_0000_0000_1000, 9'd2, 5'd13, 1, 1);
    issue(64'h0000_0000_0000_1000, 9'h1FF, 5'd14, 0, 1);
    issue(64'h0000_0000_0000_1003, 9'd0, 5'd15, 1, 0);
    issue(64'hFFFF_FFFF_FFFF_FFF0, 9'd16, 5'd31, 1, 0);

    for (int i = 0; i < 200; i++) begin
      logic [63:0] b;
      logic [8:0]  o;
      b = {$urandom, $urandom};
      o = 9'($urandom);
      if (($urandom % 4) != 0) begin
        b[1:0] = 2'b00; o[1:0] = 2'b00;
      end
      issue(b, o, 5'($urandom), 1'($urandom), 1'($urandom));
      if (($urandom % 5) == 0) repeat (1 + $urandom % 3) @(negedge clk);
    end

    for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0 && paddr_q.size() == 0, "R6", "all results drained",
        64'(exp_q.size()), 64'd0);
    done = 1;
    summary();
    $finish;
  end
endmodule